// File: doc/BRIEF.md
# Programming Track Task Arbiter

This block takes decoder-programming requests aimed at one reserved system slot and decides at once what happens to each. It answers every request it accepts for handling on the cycle after the request with an acknowledge code. At most one service-track task runs at a time. Mainline (operations-mode) requests are passed straight to a separate mainline port, even while the service track is busy. When a task ends, the block issues one completion record. The record echoes the request and carries a four-bit status.

The service track itself is reached through a small engine handshake. The block raises a start pulse with the decoded task kind and the task fields. The engine later returns a done strobe with write-acknowledge, read-acknowledge and track-empty flags and the byte it read back. A command of zero aborts the running task. A run-time timeout limit ends a task whose engine never answers. The busy state is also folded into bit 3 of a track status byte used by slot read replies.

Command byte layout: bit 0 = type bit 0, bit 1 = type bit 1, bit 2 = mainline mode, bit 3 = byte mode, bit 4 = write. Status layout: bit 3 = aborted by user, bit 2 = no read acknowledge, bit 1 = no write acknowledge, bit 0 = track empty.

Top module: `prog_track_arbiter`

## Requirements
- R1: A request whose slot number is not 0x7C causes no acknowledge, no engine start, no mainline dispatch and no completion record.
- R2: A non-zero service request (bit 2 clear) with type 00, 01 or 10 that arrives while idle gets acknowledge code 1 on the next cycle. On that same cycle it raises eng_start for one cycle and sets busy.
- R3: A service request that arrives while busy gets acknowledge code 0 and starts nothing.
- R4: A mainline request that writes (bit 4 set) or that arrives while fb_present is 1 gets acknowledge code 1, raises ops_go and gives a completion record with status 0 on the next cycle, also while the service track is busy.
- R5: A mainline read request while fb_present is 0 gets acknowledge code 0x7F and gives neither ops_go nor a completion record.
- R6: A command of 0 gets acknowledge code 1. While busy it ends the task: eng_abort is raised, busy clears, and the completion record echoes the running task with status 0x8. While idle it does nothing else.
- R7: When the engine signals done, the status is built as follows. A write without write acknowledge sets bit 1. A read without read acknowledge sets bit 2. The track-empty flag sets bit 0. A read that succeeds returns eng_rd_data in the record's data field; otherwise the data field echoes the request.
- R8: A paged read (type 00, read) whose engine reports no write acknowledge ends with status bit 1 only, whatever the read acknowledge says, and the data is echoed.
- R9: A service request with type 11 gets acknowledge code 1 and a completion record with status 0 on the next cycle. It starts no engine task and does not set busy.
- R10: If no done arrives within tmo_limit+1 cycles after the start, the task ends with eng_abort and status 0x4 for a read or 0x2 for a write.
- R11: trk_stat equals trk_base with bit 3 replaced by busy.
- R12: If a service task ends in the same cycle that a mainline request is accepted, the service record comes out first and the mainline record follows one cycle later.
- R13: The task kind on eng_kind/ops_kind is coded as follows. Service mode: type 00 = 0 (paged), type 01 = 1 with byte mode or 2 without, type 10 = 3, type 11 = 4. Mainline mode: type bit 0 clear = 5 with byte mode or 7 without; type bit 0 set = 6 with byte mode or 8 without.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_slot | input | 7 | Target slot number |
| req_cmd | input | 7 | Command byte |
| req_adr_hi | input | 7 | Mainline decoder address, high part |
| req_adr_lo | input | 7 | Mainline decoder address, low part |
| req_cv | input | 10 | Configuration variable number |
| req_data | input | 8 | Data byte |
| fb_present | input | 1 | Mainline feedback detection is installed |
| tmo_limit | input | TMO_W | Engine timeout limit in cycles |
| trk_base | input | 8 | Track status byte before the busy bit is merged |
| ack_valid | output | 1 | Acknowledge strobe |
| ack_code | output | 7 | Acknowledge code |
| busy | output | 1 | Service task running |
| trk_stat | output | 8 | Track status byte with busy in bit 3 |
| eng_start | output | 1 | Service engine start pulse |
| eng_abort | output | 1 | Service engine stop pulse |
| eng_kind | output | 4 | Task kind of the service task |
| eng_write | output | 1 | Service task writes |
| eng_cv | output | 10 | Service task CV number |
| eng_data | output | 8 | Service task write data |
| eng_done | input | 1 | Engine finished |
| eng_rd_ack | input | 1 | Engine saw read acknowledge |
| eng_wr_ack | input | 1 | Engine saw write acknowledge |
| eng_empty | input | 1 | Track found empty |
| eng_rd_data | input | 8 | Byte read back |
| ops_go | output | 1 | Mainline dispatch pulse |
| ops_kind | output | 4 | Task kind of the mainline task |
| ops_adr | output | 14 | Mainline decoder address |
| ops_cv | output | 10 | Mainline CV number |
| ops_data | output | 8 | Mainline data |
| ops_write | output | 1 | Mainline task writes |
| rpt_valid | output | 1 | Completion record strobe |
| rpt_cmd | output | 7 | Echoed command |
| rpt_adr_hi | output | 7 | Echoed address high |
| rpt_adr_lo | output | 7 | Echoed address low |
| rpt_cv | output | 10 | Echoed CV number |
| rpt_data | output | 8 | Read data or echoed data |
| rpt_stat | output | 4 | Completion status |

## Verification
The assertions assume that the engine raises eng_done only while a task is running, and only for one cycle. They also assume that the caller presents at most one request per cycle and that tmo_limit stays constant while a task runs. The stimulus drives eng_done only after a sampled start, and only on a cycle where busy is seen high. It issues requests one per cycle through a single task. It changes tmo_limit only while the block is idle. The single overlap case of R12 is built on purpose by timing a done strobe into the same edge as a mainline request.

// File: rtl/prog_arb_pkg.sv
package prog_arb_pkg;
    localparam int SLOT_W = 7;
    localparam int CMD_W  = 7;
    localparam int ADR_W  = 7;
    localparam int CV_W   = 10;
    localparam int DAT_W  = 8;
    localparam int ST_W   = 4;
    localparam int ACK_W  = 7;

    localparam logic [SLOT_W-1:0] PROG_SLOT = 7'h7C;
    localparam logic [ACK_W-1:0]  ACK_BUSY  = 7'h00;
    localparam logic [ACK_W-1:0]  ACK_OK    = 7'h01;
    localparam logic [ACK_W-1:0]  ACK_NOFB  = 7'h7F;

    // command bit positions
    localparam int B_TY0  = 0;
    localparam int B_TY1  = 1;
    localparam int B_OPS  = 2;
    localparam int B_BYTE = 3;
    localparam int B_WR   = 4;

    // status bit positions
    localparam int S_EMPTY = 0;
    localparam int S_NOWR  = 1;
    localparam int S_NORD  = 2;
    localparam int S_ABORT = 3;

    typedef enum logic [3:0] {
        K_PAGED       = 4'd0,
        K_DIR_BYTE    = 4'd1,
        K_DIR_BIT     = 4'd2,
        K_PHYS        = 4'd3,
        K_RSVD        = 4'd4,
        K_OPS_BYTE    = 4'd5,
        K_OPS_BYTE_FB = 4'd6,
        K_OPS_BIT     = 4'd7,
        K_OPS_BIT_FB  = 4'd8
    } task_kind_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [ADR_W-1:0] adr_hi;
        logic [ADR_W-1:0] adr_lo;
        logic [CV_W-1:0]  cv;
        logic [DAT_W-1:0] data;
    } prog_req_t;

    typedef struct packed {
        prog_req_t        req;
        logic [ST_W-1:0]  stat;
    } prog_rpt_t;

    function automatic task_kind_e kind_of(input logic [CMD_W-1:0] c);
        task_kind_e k;
        if (c[B_OPS]) begin
            if (c[B_TY0]) k = c[B_BYTE] ? K_OPS_BYTE_FB : K_OPS_BIT_FB;
            else          k = c[B_BYTE] ? K_OPS_BYTE    : K_OPS_BIT;
        end else begin
            case ({c[B_TY1], c[B_TY0]})
                2'b00:   k = K_PAGED;
                2'b01:   k = c[B_BYTE] ? K_DIR_BYTE : K_DIR_BIT;
                2'b10:   k = K_PHYS;
                default: k = K_RSVD;
            endcase
        end
        return k;
    endfunction
endpackage

// File: rtl/ptk_cmd_decode.sv
module ptk_cmd_decode
    import prog_arb_pkg::*;
(
    input  logic              req_valid,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              busy,
    input  logic              fb_present,
    output logic              hit,
    output logic              abort_req,
    output logic              ops_accept,
    output logic              svc_start,
    output logic              svc_rsvd,
    output task_kind_e        kind,
    output logic [ACK_W-1:0]  ack_code
);
    logic is_ops, is_svc, ops_nofb, svc_reject;

    always_comb begin
        hit        = req_valid && (req_slot == PROG_SLOT);
        abort_req  = hit && (req_cmd == '0);
        kind       = kind_of(req_cmd);
        is_ops     = hit && !abort_req && req_cmd[B_OPS];
        is_svc     = hit && !abort_req && !req_cmd[B_OPS];
        ops_nofb   = is_ops && !req_cmd[B_WR] && !fb_present;
        ops_accept = is_ops && !ops_nofb;
        svc_reject = is_svc && busy;
        svc_rsvd   = is_svc && !busy && (kind == K_RSVD);
        svc_start  = is_svc && !busy && (kind != K_RSVD);
        if (ops_nofb)        ack_code = ACK_NOFB;
        else if (svc_reject) ack_code = ACK_BUSY;
        else                 ack_code = ACK_OK;
    end
endmodule

// File: rtl/ptk_svc_seq.sv
module ptk_svc_seq
    import prog_arb_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort_req,
    input  prog_req_t        req,
    input  task_kind_e       kind,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             eng_done,
    input  logic             eng_rd_ack,
    input  logic             eng_wr_ack,
    input  logic             eng_empty,
    input  logic [DAT_W-1:0] eng_rd_data,
    output logic             running,
    output logic             eng_start,
    output logic             eng_abort,
    output prog_req_t        cur,
    output task_kind_e       cur_kind,
    output logic             fin,
    output prog_rpt_t        fin_rpt
);
    logic [TMO_W-1:0] cnt;
    logic             wr, page_fail, tmo_hit;

    always_comb begin
        wr        = cur.cmd[B_WR];
        page_fail = !wr && (cur_kind == K_PAGED) && !eng_wr_ack;
        tmo_hit   = (cnt == tmo_limit);
        fin       = running && (abort_req || eng_done || tmo_hit);
        fin_rpt   = '{req: cur, stat: '0};
        if (abort_req) begin
            fin_rpt.stat[S_ABORT] = 1'b1;
        end else if (eng_done) begin
            fin_rpt.stat[S_NOWR]  = wr ? !eng_wr_ack : page_fail;
            fin_rpt.stat[S_NORD]  = !wr && !page_fail && !eng_rd_ack;
            fin_rpt.stat[S_EMPTY] = eng_empty;
            if (!wr && !page_fail && eng_rd_ack) fin_rpt.req.data = eng_rd_data;
        end else begin
            fin_rpt.stat[S_NOWR] = wr;
            fin_rpt.stat[S_NORD] = !wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
            cnt       <= '0;
            cur       <= '0;
            cur_kind  <= K_PAGED;
        end else begin
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
            if (!running) begin
                if (start) begin
                    running   <= 1'b1;
                    eng_start <= 1'b1;
                    cur       <= req;
                    cur_kind  <= kind;
                    cnt       <= '0;
                end
            end else if (fin) begin
                running   <= 1'b0;
                eng_abort <= !eng_done || abort_req;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !running) |=> (running && eng_start));
    // R6
    abort_ends_task_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_req && running) |=> (eng_abort && !running));
    // R7
    done_ends_task_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && running) |=> !running);
endmodule

// File: rtl/ptk_report_mux.sv
module ptk_report_mux
    import prog_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      svc_fin,
    input  prog_rpt_t svc_rpt,
    input  logic      imm_valid,
    input  prog_rpt_t imm_rpt,
    output logic      rpt_valid,
    output prog_rpt_t rpt
);
    logic      pend_v;
    prog_rpt_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_valid <= 1'b0;
            rpt       <= '0;
            pend_v    <= 1'b0;
            pend      <= '0;
        end else begin
            rpt_valid <= svc_fin || pend_v || imm_valid;
            if (svc_fin) begin
                rpt    <= svc_rpt;
                pend_v <= imm_valid;
                pend   <= imm_rpt;
            end else if (pend_v) begin
                rpt    <= pend;
                pend_v <= imm_valid;
                pend   <= imm_rpt;
            end else if (imm_valid) begin
                rpt    <= imm_rpt;
            end
        end
    end

    // R12
    no_double_pending_chk: assert property (@(posedge clk) disable iff (rst)
        !(svc_fin && pend_v));
endmodule

// File: rtl/prog_track_arbiter.sv
module prog_track_arbiter
    import prog_arb_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [SLOT_W-1:0]  req_slot,
    input  logic [CMD_W-1:0]   req_cmd,
    input  logic [ADR_W-1:0]   req_adr_hi,
    input  logic [ADR_W-1:0]   req_adr_lo,
    input  logic [CV_W-1:0]    req_cv,
    input  logic [DAT_W-1:0]   req_data,
    input  logic               fb_present,
    input  logic [TMO_W-1:0]   tmo_limit,
    input  logic [7:0]         trk_base,
    output logic               ack_valid,
    output logic [ACK_W-1:0]   ack_code,
    output logic               busy,
    output logic [7:0]         trk_stat,
    output logic               eng_start,
    output logic               eng_abort,
    output logic [3:0]         eng_kind,
    output logic               eng_write,
    output logic [CV_W-1:0]    eng_cv,
    output logic [DAT_W-1:0]   eng_data,
    input  logic               eng_done,
    input  logic               eng_rd_ack,
    input  logic               eng_wr_ack,
    input  logic               eng_empty,
    input  logic [DAT_W-1:0]   eng_rd_data,
    output logic               ops_go,
    output logic [3:0]         ops_kind,
    output logic [2*ADR_W-1:0] ops_adr,
    output logic [CV_W-1:0]    ops_cv,
    output logic [DAT_W-1:0]   ops_data,
    output logic               ops_write,
    output logic               rpt_valid,
    output logic [CMD_W-1:0]   rpt_cmd,
    output logic [ADR_W-1:0]   rpt_adr_hi,
    output logic [ADR_W-1:0]   rpt_adr_lo,
    output logic [CV_W-1:0]    rpt_cv,
    output logic [DAT_W-1:0]   rpt_data,
    output logic [ST_W-1:0]    rpt_stat
);
    localparam int BUSY_BIT = 3;

    prog_req_t        req;
    prog_rpt_t        imm_rpt, svc_rpt, rpt;
    logic             hit, abort_req, ops_accept, svc_start, svc_rsvd, svc_fin;
    logic [ACK_W-1:0] dec_ack;
    task_kind_e       kind, cur_kind;
    prog_req_t        cur;

    assign req     = '{cmd: req_cmd, adr_hi: req_adr_hi, adr_lo: req_adr_lo,
                       cv: req_cv, data: req_data};
    assign imm_rpt = '{req: req, stat: '0};

    ptk_cmd_decode u_dec (
        .req_valid (req_valid), .req_slot (req_slot), .req_cmd (req_cmd),
        .busy (busy), .fb_present (fb_present), .hit (hit),
        .abort_req (abort_req), .ops_accept (ops_accept), .svc_start (svc_start),
        .svc_rsvd (svc_rsvd), .kind (kind), .ack_code (dec_ack)
    );

    ptk_svc_seq #(.TMO_W(TMO_W)) u_seq (
        .clk (clk), .rst (rst), .start (svc_start), .abort_req (abort_req),
        .req (req), .kind (kind), .tmo_limit (tmo_limit),
        .eng_done (eng_done), .eng_rd_ack (eng_rd_ack), .eng_wr_ack (eng_wr_ack),
        .eng_empty (eng_empty), .eng_rd_data (eng_rd_data),
        .running (busy), .eng_start (eng_start), .eng_abort (eng_abort),
        .cur (cur), .cur_kind (cur_kind), .fin (svc_fin), .fin_rpt (svc_rpt)
    );

    ptk_report_mux u_mux (
        .clk (clk), .rst (rst), .svc_fin (svc_fin), .svc_rpt (svc_rpt),
        .imm_valid (ops_accept || svc_rsvd), .imm_rpt (imm_rpt),
        .rpt_valid (rpt_valid), .rpt (rpt)
    );

    always_comb begin
        eng_kind  = cur_kind;
        eng_write = cur.cmd[B_WR];
        eng_cv    = cur.cv;
        eng_data  = cur.data;
        trk_stat  = trk_base;
        trk_stat[BUSY_BIT] = busy;
        rpt_cmd    = rpt.req.cmd;
        rpt_adr_hi = rpt.req.adr_hi;
        rpt_adr_lo = rpt.req.adr_lo;
        rpt_cv     = rpt.req.cv;
        rpt_data   = rpt.req.data;
        rpt_stat   = rpt.stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_valid <= 1'b0;
            ack_code  <= ACK_BUSY;
            ops_go    <= 1'b0;
            ops_kind  <= '0;
            ops_adr   <= '0;
            ops_cv    <= '0;
            ops_data  <= '0;
            ops_write <= 1'b0;
        end else begin
            ack_valid <= hit;
            ack_code  <= dec_ack;
            ops_go    <= ops_accept;
            if (ops_accept) begin
                ops_kind  <= kind;
                ops_adr   <= {req_adr_hi, req_adr_lo};
                ops_cv    <= req_cv;
                ops_data  <= req_data;
                ops_write <= req_cmd[B_WR];
            end
        end
    end

    // R3
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_slot == PROG_SLOT && req_cmd != '0 && !req_cmd[B_OPS] && busy)
        |=> (ack_valid && ack_code == ACK_BUSY && !eng_start));
    // R4
    ops_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_slot == PROG_SLOT && req_cmd[B_OPS] && req_cmd[B_WR])
        |=> (ops_go && ack_code == ACK_OK));
    // R1
    foreign_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (req_slot != PROG_SLOT && !busy) |=> (!ack_valid && !eng_start && !ops_go));
endmodule

// File: tb/tb_prog_track_arbiter.sv
`timescale 1ns/1ps
module tb_prog_track_arbiter;
    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic req_valid = 0; logic [6:0] req_slot = 0, req_cmd = 0;
    logic [6:0] req_adr_hi = 7'h12, req_adr_lo = 7'h34;
    logic [9:0] req_cv = 0; logic [7:0] req_data = 0;
    logic fb_present = 0; logic [15:0] tmo_limit = 16'd200; logic [7:0] trk_base = 8'hA5;
    logic ack_valid, busy, eng_start, eng_abort, eng_write, ops_go, ops_write, rpt_valid;
    logic [6:0] ack_code, rpt_cmd, rpt_adr_hi, rpt_adr_lo;
    logic [7:0] trk_stat, eng_data, ops_data, rpt_data;
    logic [3:0] eng_kind, ops_kind, rpt_stat;
    logic [9:0] eng_cv, ops_cv, rpt_cv; logic [13:0] ops_adr;
    logic eng_done = 0, eng_rd_ack = 0, eng_wr_ack = 0, eng_empty = 0;
    logic [7:0] eng_rd_data = 0;

    prog_track_arbiter dut (.*);

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, let one edge pass, sample at the following negedge
    task automatic send(input logic [6:0] slot, input logic [6:0] cmd,
                        input logic [9:0] cv, input logic [7:0] data);
        req_valid = 1; req_slot = slot; req_cmd = cmd; req_cv = cv; req_data = data;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_eng(input bit wa, input bit ra, input bit em, input logic [7:0] rd);
        eng_done = 1; eng_wr_ack = wa; eng_rd_ack = ra; eng_empty = em; eng_rd_data = rd;
        @(posedge clk); @(negedge clk);
        eng_done = 0; eng_wr_ack = 0; eng_rd_ack = 0; eng_empty = 0;
    endtask

    typedef struct packed {
        logic [6:0] slot; logic [6:0] cmd; logic fb; logic ackv; logic [6:0] ack;
        logic start; logic go; logic rpt; logic [3:0] kind;
    } vec_t;

    // cmd: b0 ty0, b1 ty1, b2 ops, b3 byte, b4 write
    localparam vec_t VECS [13] = '{
        '{7'h10, 7'h18, 1'b0, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0, 4'd0}, // R1
        '{7'h7C, 7'h18, 1'b0, 1'b1, 7'h01, 1'b1, 1'b0, 1'b0, 4'd0}, // R2 R13 paged
        '{7'h7C, 7'h09, 1'b0, 1'b1, 7'h01, 1'b1, 1'b0, 1'b0, 4'd1}, // R13 direct byte
        '{7'h7C, 7'h11, 1'b0, 1'b1, 7'h01, 1'b1, 1'b0, 1'b0, 4'd2}, // R13 direct bit
        '{7'h7C, 7'h0A, 1'b0, 1'b1, 7'h01, 1'b1, 1'b0, 1'b0, 4'd3}, // R13 phys
        '{7'h7C, 7'h0B, 1'b0, 1'b1, 7'h01, 1'b0, 1'b0, 1'b1, 4'd4}, // R9
        '{7'h7C, 7'h1C, 1'b0, 1'b1, 7'h01, 1'b0, 1'b1, 1'b1, 4'd5}, // R4
        '{7'h7C, 7'h0D, 1'b1, 1'b1, 7'h01, 1'b0, 1'b1, 1'b1, 4'd6}, // R4 fb
        '{7'h7C, 7'h0D, 1'b0, 1'b1, 7'h7F, 1'b0, 1'b0, 1'b0, 4'd0}, // R5
        '{7'h7C, 7'h14, 1'b0, 1'b1, 7'h01, 1'b0, 1'b1, 1'b1, 4'd7}, // R13 ops bit
        '{7'h7C, 7'h05, 1'b1, 1'b1, 7'h01, 1'b0, 1'b1, 1'b1, 4'd8}, // R13 ops bit fb
        '{7'h7C, 7'h00, 1'b0, 1'b1, 7'h01, 1'b0, 1'b0, 1'b0, 4'd0}, // R6 idle abort
        '{7'h7B, 7'h0B, 1'b0, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0, 4'd0}  // R1
    };

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state, R11
        chk(!ack_valid && !busy && !rpt_valid && !eng_start, "R2 reset idle", busy, 0);
        chk(trk_stat == 8'hA5 & ~8'h08, "R11 idle trk_stat", trk_stat, 8'hA5 & ~8'h08);

        foreach (VECS[i]) begin
            fb_present = VECS[i].fb;
            send(VECS[i].slot, VECS[i].cmd, 10'(i), 8'(i));
            chk(ack_valid == VECS[i].ackv, "R1 ack_valid", ack_valid, VECS[i].ackv);
            if (VECS[i].ackv) chk(ack_code == VECS[i].ack, "R2/R5 ack_code", ack_code, VECS[i].ack);
            chk(eng_start == VECS[i].start && busy == VECS[i].start, "R2 start/busy", eng_start, VECS[i].start);
            chk(ops_go == VECS[i].go, "R4/R5 ops_go", ops_go, VECS[i].go);
            chk(rpt_valid == VECS[i].rpt, "R9/R4 rpt_valid", rpt_valid, VECS[i].rpt);
            if (VECS[i].rpt) chk(rpt_stat == 0 && rpt_cmd == VECS[i].cmd, "R9/R4 rpt", rpt_stat, 0);
            if (VECS[i].start) chk(eng_kind == VECS[i].kind, "R13 eng_kind", eng_kind, VECS[i].kind);
            if (VECS[i].go) chk(ops_kind == VECS[i].kind, "R13 ops_kind", ops_kind, VECS[i].kind);
            if (VECS[i].start) begin
                finish_eng(1, 1, 0, 8'h00);
                chk(rpt_valid && !busy, "R7 cleanup done", busy, 0);
            end
        end
        fb_present = 0;

        // R3 busy rejection, R11 busy bit, R4 bypass while busy
        send(7'h7C, 7'h18, 10'h155, 8'h3C);
        chk(busy && trk_stat == (8'hA5 | 8'h08), "R11 busy trk_stat", trk_stat, 8'hAD);
        chk(eng_cv == 10'h155 && eng_write, "R2 eng fields", eng_cv, 10'h155);
        send(7'h7C, 7'h09, 10'h001, 8'h00);
        chk(ack_valid && ack_code == 7'h00 && !eng_start, "R3 reject", ack_code, 0);
        send(7'h7C, 7'h1C, 10'h077, 8'h11);
        chk(ack_code == 7'h01 && ops_go && rpt_valid && rpt_stat == 0 && rpt_cv == 10'h077,
            "R4 ops while busy", rpt_cv, 10'h077);
        chk(ops_adr == 14'h0934 && ops_write, "R4 ops fields", ops_adr, 14'h0934);
        // R7 write without ack
        finish_eng(0, 0, 0, 8'h00);
        chk(rpt_valid && rpt_stat == 4'h2 && rpt_cv == 10'h155, "R7 write noack", rpt_stat, 2);

        // R7 read success returns data
        send(7'h7C, 7'h09, 10'h020, 8'h00);
        finish_eng(1, 1, 0, 8'hC3);
        chk(rpt_valid && rpt_stat == 0 && rpt_data == 8'hC3, "R7 read data", rpt_data, 8'hC3);
        // R7 read fail with empty track
        send(7'h7C, 7'h09, 10'h021, 8'h5A);
        finish_eng(1, 0, 1, 8'hC3);
        chk(rpt_stat == 4'h5 && rpt_data == 8'h5A, "R7 read fail empty", rpt_stat, 5);

        // R8 paged read, page write not acknowledged
        send(7'h7C, 7'h08, 10'h030, 8'h66);
        finish_eng(0, 1, 0, 8'h99);
        chk(rpt_valid && rpt_stat == 4'h2 && rpt_data == 8'h66, "R8 paged fail", rpt_stat, 2);

        // R6 abort while running
        send(7'h7C, 7'h09, 10'h040, 8'h00);
        send(7'h7C, 7'h00, 10'h000, 8'h00);
        chk(ack_code == 7'h01 && eng_abort && !busy, "R6 abort ends", busy, 0);
        chk(rpt_valid && rpt_stat == 4'h8 && rpt_cv == 10'h040 && rpt_cmd == 7'h09,
            "R6 abort report", rpt_stat, 8);

        // R10 timeout, read then write
        tmo_limit = 16'd4;
        for (int w = 0; w < 2; w++) begin
            int n;
            send(7'h7C, w ? 7'h19 : 7'h09, 10'h050, 8'h00);
            n = 0;
            while (!rpt_valid && n < 20) begin @(negedge clk); n++; end
            chk(rpt_valid && eng_abort && !busy, "R10 timeout end", n, 5);
            chk(rpt_stat == (w ? 4'h2 : 4'h4), "R10 timeout stat", rpt_stat, w ? 2 : 4);
        end
        tmo_limit = 16'd200;

        // R12 service end and ops accept on the same edge
        send(7'h7C, 7'h18, 10'h060, 8'h00);
        eng_done = 1; eng_wr_ack = 1;
        send(7'h7C, 7'h1C, 10'h061, 8'h00);
        eng_done = 0; eng_wr_ack = 0;
        chk(rpt_valid && rpt_cmd == 7'h18 && rpt_cv == 10'h060, "R12 service first", rpt_cv, 10'h060);
        @(negedge clk);
        chk(rpt_valid && rpt_cmd == 7'h1C && rpt_cv == 10'h061, "R12 ops next", rpt_cv, 10'h061);
        @(negedge clk);
        chk(!rpt_valid, "R12 no extra", rpt_valid, 0);

        summary();
    end
endmodule